// File: doc/BRIEF.md
# Conditional Event-Triggered Pulse Generator

This block sits at the receiving end of an event distribution link and turns one chosen event code into a timed electrical-style pulse. Event codes of 8 bits arrive at most one per event clock on a valid/ready input. When the configured trigger code is accepted, the block waits a programmable number of event clock cycles and then drives its pulse output high for a programmable number of cycles.

The delay is conditional. Up to `N_SUPP` suppress slots each hold a code such as a "laser off" or "RF off" event. When an enabled slot's code has been accepted since the last sequence-start code, the next trigger uses an alternate delay instead of the normal one. This lets a downstream laser or RF station keep firing at its fixed rate while moving its timing away from the beam. The choice is made entirely in hardware from the codes already received, within the event clock.

The event input never applies back-pressure. `ev_ready` is held high out of reset, and every cycle with `ev_valid` high delivers exactly one code. A code offered with `ev_valid` low is not consumed and has no effect. The configuration inputs are plain levels that the block samples when it needs them.

Top module: `evtrig_pulse_gen`

## Requirements
- R1: While `rst_n` is low and in the cycle after it rises, `pulse_out` is low and no suppress event is recorded.
- R2: `ev_ready` is high in every cycle after reset. A code is consumed exactly when `ev_valid` is high.
- R3: The block may accept the trigger code while idle with width W > 0. Call the accepting clock edge edge 0. With delay D selected, `pulse_out` is high after edges D+1 through D+W, which is W cycles, and low otherwise.
- R4: A trigger accepted while `cfg_width` is 0 gives no pulse, and the block stays ready for the next trigger.
- R5: Suppress slot i uses the code in `cfg_supp_code[i*8 +: 8]` and is enabled by `cfg_supp_en[i]`. Accepting that code records slot i. While any slot is recorded, a trigger uses `cfg_delay_alt` instead of `cfg_delay_norm`.
- R6: Accepting `cfg_start_code` clears every recorded slot. When the same code also matches a slot, the clear takes priority. A trigger uses the records as they stood before the current code.
- R7: Code 0x00 is null. It never acts as a trigger, start or suppress code, even when a configuration register holds 0x00.
- R8: A code presented with `ev_valid` low neither triggers nor records nor clears.
- R9: A trigger code arriving while a pulse is pending or high is ignored. Only the first pulse appears.
- R10: The selected delay and the width are captured at the accepting edge. Later changes to `cfg_delay_norm`, `cfg_delay_alt` or `cfg_width` do not alter a pulse already under way.
- R11: A slot whose enable bit is 0 does not record its code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Event clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_valid | input | 1 | Event code present this cycle |
| ev_code | input | CODE_W | Event code |
| ev_ready | output | 1 | Always high after reset; no back-pressure |
| cfg_trig_code | input | CODE_W | Code that starts a pulse |
| cfg_start_code | input | CODE_W | Code that begins a new sequence and clears records |
| cfg_supp_code | input | N_SUPP*CODE_W | Suppress codes, slot i at bits i*CODE_W upward |
| cfg_supp_en | input | N_SUPP | Per-slot enable |
| cfg_delay_norm | input | CNT_W | Delay in cycles when no slot is recorded |
| cfg_delay_alt | input | CNT_W | Delay in cycles when any slot is recorded |
| cfg_width | input | CNT_W | Pulse width in cycles; 0 disables |
| pulse_out | output | 1 | Trigger pulse |

## Verification
The bench builds the block with `CNT_W` = 6 and `N_SUPP` = 2 and keeps `CODE_W` at 8. With a 6-bit counter, every delay from 0 to 5 can be crossed with every width from 1 to 4, and the full pulse shape is compared cycle by cycle against the D+1..D+W window. Two slots are enough to show that recording works per slot, that each slot can be enabled separately, and that the start code clears both. The same small counters keep the retrigger and mid-pulse reconfiguration cases short enough to check the whole window after each one.

// File: rtl/evtrig_pkg.sv
package evtrig_pkg;

  typedef enum logic [1:0] {
    PG_IDLE = 2'd0,
    PG_WAIT = 2'd1,
    PG_HIGH = 2'd2
  } pg_state_e;

  // A configured code matches only if it is not the null code.
  function automatic logic code_hit(input logic [7:0] rx, input logic [7:0] cfg);
    return (rx == cfg) && (cfg != 8'h00);
  endfunction

endpackage

// File: rtl/evtrig_decode.sv
module evtrig_decode #(
  parameter int CODE_W = 8,
  parameter int N_SUPP = 2
) (
  input  logic                     ev_valid,
  input  logic [CODE_W-1:0]        ev_code,
  input  logic [CODE_W-1:0]        cfg_trig_code,
  input  logic [CODE_W-1:0]        cfg_start_code,
  input  logic [N_SUPP*CODE_W-1:0] cfg_supp_code,
  input  logic [N_SUPP-1:0]        cfg_supp_en,
  output logic                     trig_hit,
  output logic                     start_hit,
  output logic [N_SUPP-1:0]        supp_hit
);

  localparam logic [CODE_W-1:0] NULL_CODE = '0;

  logic code_live;
  assign code_live = ev_valid && (ev_code != NULL_CODE);

  assign trig_hit  = code_live && (ev_code == cfg_trig_code);
  assign start_hit = code_live && (ev_code == cfg_start_code);

  for (genvar i = 0; i < N_SUPP; i++) begin : g_slot
    logic [CODE_W-1:0] slot_code;
    assign slot_code   = cfg_supp_code[i*CODE_W +: CODE_W];
    assign supp_hit[i] = code_live && cfg_supp_en[i] && (ev_code == slot_code);
  end

endmodule

// File: rtl/evtrig_mask_track.sv
module evtrig_mask_track #(
  parameter int N_SUPP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_hit,
  input  logic [N_SUPP-1:0] supp_hit,
  output logic [N_SUPP-1:0] seen,
  output logic              any_seen
);

  for (genvar i = 0; i < N_SUPP; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)            seen[i] <= 1'b0;
      else if (start_hit)    seen[i] <= 1'b0;
      else if (supp_hit[i])  seen[i] <= 1'b1;
    end
  end

  assign any_seen = |seen;

endmodule

// File: rtl/evtrig_pulse_timer.sv
module evtrig_pulse_timer
  import evtrig_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [CNT_W-1:0] delay_cyc,
  input  logic [CNT_W-1:0] width_cyc,
  output logic             idle,
  output logic             pulse_out
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  pg_state_e        state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] width_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= PG_IDLE;
      cnt     <= '0;
      width_q <= '0;
    end else begin
      unique case (state)
        PG_IDLE: begin
          if (go) begin
            state   <= PG_WAIT;
            cnt     <= delay_cyc;
            width_q <= width_cyc;
          end
        end
        PG_WAIT: begin
          if (cnt == '0) begin
            state <= PG_HIGH;
            cnt   <= width_q - ONE;
          end else begin
            cnt <= cnt - ONE;
          end
        end
        PG_HIGH: begin
          if (cnt == '0) state <= PG_IDLE;
          else           cnt   <= cnt - ONE;
        end
        default: state <= PG_IDLE;
      endcase
    end
  end

  assign idle      = (state == PG_IDLE);
  assign pulse_out = (state == PG_HIGH);

endmodule

// File: rtl/evtrig_pulse_gen.sv
module evtrig_pulse_gen #(
  parameter int CODE_W = 8,
  parameter int N_SUPP = 2,
  parameter int CNT_W  = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ev_valid,
  input  logic [CODE_W-1:0]        ev_code,
  output logic                     ev_ready,
  input  logic [CODE_W-1:0]        cfg_trig_code,
  input  logic [CODE_W-1:0]        cfg_start_code,
  input  logic [N_SUPP*CODE_W-1:0] cfg_supp_code,
  input  logic [N_SUPP-1:0]        cfg_supp_en,
  input  logic [CNT_W-1:0]         cfg_delay_norm,
  input  logic [CNT_W-1:0]         cfg_delay_alt,
  input  logic [CNT_W-1:0]         cfg_width,
  output logic                     pulse_out
);

  logic              trig_hit;
  logic              start_hit;
  logic [N_SUPP-1:0] supp_hit;
  logic [N_SUPP-1:0] supp_seen;
  logic              any_seen;
  logic              timer_idle;
  logic              arm_go;
  logic [CNT_W-1:0]  delay_pick;

  assign ev_ready = 1'b1;

  evtrig_decode #(.CODE_W(CODE_W), .N_SUPP(N_SUPP)) u_decode (
    .ev_valid       (ev_valid),
    .ev_code        (ev_code),
    .cfg_trig_code  (cfg_trig_code),
    .cfg_start_code (cfg_start_code),
    .cfg_supp_code  (cfg_supp_code),
    .cfg_supp_en    (cfg_supp_en),
    .trig_hit       (trig_hit),
    .start_hit      (start_hit),
    .supp_hit       (supp_hit)
  );

  evtrig_mask_track #(.N_SUPP(N_SUPP)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_hit (start_hit),
    .supp_hit  (supp_hit),
    .seen      (supp_seen),
    .any_seen  (any_seen)
  );

  // Records from earlier codes only; the current code's effect lands next cycle.
  assign delay_pick = any_seen ? cfg_delay_alt : cfg_delay_norm;
  assign arm_go     = trig_hit && timer_idle && (cfg_width != '0);

  evtrig_pulse_timer #(.CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (arm_go),
    .delay_cyc (delay_pick),
    .width_cyc (cfg_width),
    .idle      (timer_idle),
    .pulse_out (pulse_out)
  );

endmodule

// File: rtl/evtrig_pulse_gen_chk.sv
module evtrig_pulse_gen_chk #(
  parameter int CODE_W = 8,
  parameter int N_SUPP = 2,
  parameter int CNT_W  = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     ev_valid,
  input logic [CODE_W-1:0]        ev_code,
  input logic                     ev_ready,
  input logic [CODE_W-1:0]        cfg_trig_code,
  input logic [CODE_W-1:0]        cfg_start_code,
  input logic [N_SUPP*CODE_W-1:0] cfg_supp_code,
  input logic [N_SUPP-1:0]        cfg_supp_en,
  input logic [CNT_W-1:0]         cfg_width,
  input logic [N_SUPP-1:0]        seen,
  input logic                     armed,
  input logic                     idle,
  input logic                     pulse_out
);

  logic start_live;
  assign start_live = ev_valid && (ev_code == cfg_start_code) && (cfg_start_code != '0);

  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |=> (!pulse_out && seen == '0));

  assert_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ready);

  assert_arm_R3: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> !idle);

  assert_zero_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && ev_valid && ev_code == cfg_trig_code && cfg_trig_code != '0 && cfg_width == '0)
      |=> (idle && !pulse_out));

  for (genvar i = 0; i < N_SUPP; i++) begin : g_slot_chk
    assert_record_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && cfg_supp_en[i] && ev_code == cfg_supp_code[i*CODE_W +: CODE_W] &&
       ev_code != '0 && !start_live) |=> seen[i]);
    assert_disabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_supp_en[i] && !seen[i]) |=> !seen[i]);
  end

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start_live |=> (seen == '0));

  assert_null_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_code == '0) |=> ($stable(seen) && !$rose(pulse_out) || $past(!idle)));

  assert_novalid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_valid |=> $stable(seen));

  assert_retrig_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |-> !armed);

endmodule

bind evtrig_pulse_gen evtrig_pulse_gen_chk #(
  .CODE_W(CODE_W), .N_SUPP(N_SUPP), .CNT_W(CNT_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .ev_valid       (ev_valid),
  .ev_code        (ev_code),
  .ev_ready       (ev_ready),
  .cfg_trig_code  (cfg_trig_code),
  .cfg_start_code (cfg_start_code),
  .cfg_supp_code  (cfg_supp_code),
  .cfg_supp_en    (cfg_supp_en),
  .cfg_width      (cfg_width),
  .seen           (supp_seen),
  .armed          (arm_go),
  .idle           (timer_idle),
  .pulse_out      (pulse_out)
);

// File: tb/evtrig_pulse_gen_tb.sv
module evtrig_pulse_gen_tb;

  localparam int CODE_W = 8;
  localparam int N_SUPP = 2;
  localparam int CNT_W  = 6;

  localparam logic [7:0] TRIG  = 8'h21;
  localparam logic [7:0] START = 8'h01;
  localparam logic [7:0] S0    = 8'h40;
  localparam logic [7:0] S1    = 8'h41;

  logic                     clk = 1'b0;
  logic                     rst_n = 1'b0;
  logic                     ev_valid = 1'b0;
  logic [CODE_W-1:0]        ev_code = '0;
  logic                     ev_ready;
  logic [CODE_W-1:0]        cfg_trig_code = TRIG;
  logic [CODE_W-1:0]        cfg_start_code = START;
  logic [N_SUPP*CODE_W-1:0] cfg_supp_code = {S1, S0};
  logic [N_SUPP-1:0]        cfg_supp_en = 2'b11;
  logic [CNT_W-1:0]         cfg_delay_norm = '0;
  logic [CNT_W-1:0]         cfg_delay_alt = '0;
  logic [CNT_W-1:0]         cfg_width = 6'd1;
  logic                     pulse_out;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  evtrig_pulse_gen #(.CODE_W(CODE_W), .N_SUPP(N_SUPP), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_code(ev_code),
    .ev_ready(ev_ready), .cfg_trig_code(cfg_trig_code),
    .cfg_start_code(cfg_start_code), .cfg_supp_code(cfg_supp_code),
    .cfg_supp_en(cfg_supp_en), .cfg_delay_norm(cfg_delay_norm),
    .cfg_delay_alt(cfg_delay_alt), .cfg_width(cfg_width), .pulse_out(pulse_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // One code for one cycle; returns at the negedge after the accepting edge.
  task automatic send(input logic [7:0] code, input bit vld);
    @(negedge clk);
    ev_valid = vld;
    ev_code  = code;
    @(negedge clk);
    ev_valid = 1'b0;
    ev_code  = '0;
  endtask

  // Fire the trigger, expect high for samples k in [d+1, d+w].
  // rk >= 0 re-sends the trigger at sample rk; chg alters config at sample 1.
  task automatic fire(input int d, input int w, input int rk, input bit chg, input string req);
    int bad = 0;
    int first_k = -1;
    int first_v = 0;
    int last_k;
    logic [CNT_W-1:0] sv_n, sv_a, sv_w;
    sv_n = cfg_delay_norm; sv_a = cfg_delay_alt; sv_w = cfg_width;
    last_k = d + w + 3 + ((rk >= 0) ? (rk + d + w + 2) : 0);
    send(TRIG, 1'b1);
    for (int k = 0; k <= last_k; k++) begin
      bit expv;
      expv = (k >= d + 1) && (k <= d + w);
      if (pulse_out !== expv) begin
        bad++;
        if (first_k < 0) begin first_k = k; first_v = int'(pulse_out); end
      end
      ev_valid = (k == rk);
      ev_code  = (k == rk) ? TRIG : 8'h00;
      if (chg && k == 1) begin
        cfg_delay_norm = sv_n + 6'd3;
        cfg_delay_alt  = sv_a + 6'd3;
        cfg_width      = sv_w + 6'd2;
      end
      @(negedge clk);
    end
    ev_valid = 1'b0;
    ev_code  = '0;
    cfg_delay_norm = sv_n; cfg_delay_alt = sv_a; cfg_width = sv_w;
    if (bad != 0)
      $display("  %s: d=%0d w=%0d first mismatch at sample %0d", req, d, w, first_k);
    check(bad == 0, req, first_v, (first_k >= d + 1 && first_k <= d + w) ? 1 : 0);
  endtask

  task automatic quiet(input int n, input string req);
    int highs = 0;
    for (int k = 0; k < n; k++) begin
      if (pulse_out !== 1'b0) highs++;
      @(negedge clk);
    end
    check(highs == 0, req, highs, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(pulse_out === 1'b0, "R1 pulse low in reset", int'(pulse_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(pulse_out === 1'b0, "R1 pulse low after reset", int'(pulse_out), 0);
    check(ev_ready === 1'b1, "R2 ready high", int'(ev_ready), 1);

    // R3: sweep normal delay and width with no record (alt kept distinct).
    for (int d = 0; d <= 5; d++) begin
      for (int w = 1; w <= 4; w++) begin
        cfg_delay_norm = CNT_W'(d);
        cfg_delay_alt  = CNT_W'(d + 7);
        cfg_width      = CNT_W'(w);
        fire(d, w, -1, 1'b0, "R3 normal delay sweep");
      end
    end

    // R5: slot 0 recorded -> alternate delay for every later trigger.
    cfg_delay_norm = 6'd2;
    cfg_width      = 6'd2;
    send(S0, 1'b1);
    for (int a = 0; a <= 4; a++) begin
      cfg_delay_alt = CNT_W'(a);
      fire(a, 2, -1, 1'b0, "R5 alt delay after slot0");
    end
    check(ev_ready === 1'b1, "R2 ready during traffic", int'(ev_ready), 1);

    // R6: start code clears records.
    cfg_delay_alt = 6'd9;
    send(START, 1'b1);
    fire(2, 2, -1, 1'b0, "R6 normal delay after start");

    // R5: slot 1 alone.
    send(S1, 1'b1);
    fire(9, 2, -1, 1'b0, "R5 alt delay after slot1");
    send(START, 1'b1);

    // R11: disabled slot does not record.
    cfg_supp_en = 2'b01;
    send(S1, 1'b1);
    fire(2, 2, -1, 1'b0, "R11 disabled slot ignored");
    cfg_supp_en = 2'b11;

    // R7: null code never matches a slot or a trigger.
    cfg_supp_code = {S1, 8'h00};
    send(8'h00, 1'b1);
    fire(2, 2, -1, 1'b0, "R7 null code not recorded");
    cfg_supp_code = {S1, S0};
    cfg_trig_code = 8'h00;
    send(8'h00, 1'b1);
    quiet(12, "R7 null code not a trigger");
    cfg_trig_code = TRIG;

    // R8: codes without valid have no effect.
    send(S0, 1'b0);
    fire(2, 2, -1, 1'b0, "R8 invalid suppress ignored");
    send(TRIG, 1'b0);
    quiet(12, "R8 invalid trigger ignored");

    // R4: zero width gives no pulse and leaves the block ready.
    cfg_width = 6'd0;
    send(TRIG, 1'b1);
    quiet(12, "R4 zero width no pulse");
    cfg_width = 6'd3;
    fire(2, 3, -1, 1'b0, "R4 next trigger accepted");

    // R9: retrigger during delay and during last high cycle.
    cfg_delay_norm = 6'd4;
    fire(4, 3, 2, 1'b0, "R9 retrigger while pending");
    fire(4, 3, 7, 1'b0, "R9 retrigger on last high cycle");

    // R10: config changes mid-pulse do not disturb it.
    cfg_delay_norm = 6'd3;
    cfg_width      = 6'd2;
    fire(3, 2, -1, 1'b1, "R10 latched delay and width");

    summary();
    $finish;
  end

endmodule